// File: doc/BRIEF.md
# MII transmit to RMII transmit converter

This block sits between a MAC that transmits over a 4-bit MII and a PHY that accepts the 2-bit RMII. From the 50 MHz reference clock it makes the MII transmit clock for the MAC. On the reference edge where that clock rises it takes one nibble, with its enable and error flags. It then sends the nibble to the PHY as two dibits, low pair first. The RMII data and enable change only on reference clock edges, so the PHY can sample them on the next rising edge.

The line rate is fixed at elaboration by a parameter. At 100 Mbps each dibit lasts one reference cycle, so the MII clock runs at 25 MHz. At 10 Mbps each dibit is held for ten reference cycles, so the MII clock period is twenty cycles. Suppose the MAC flags a transmit error while a frame is in progress. From that nibble on, the block replaces all outgoing data with the pattern `01` until the MAC drops transmit enable. The PHY then sees a recognisably damaged frame instead of part of a valid one.

Top module: `mii_rmii_tx_bridge`

## Requirements
- R1: While rst_ni is low, rmii_tx_en_o, rmii_txd_o and mii_tx_clk_o are all 0, whatever the MII inputs do.
- R2: mii_tx_clk_o alternates between high and low phases that each last D reference cycles, where D is 1 at 100 Mbps and 10 at 10 Mbps. A nibble is captured on the reference edge where it rises.
- R3: Starting at the edge after capture, rmii_txd_o carries nibble bits [1:0] for D cycles while mii_tx_clk_o is high.
- R4: For the D cycles after that, rmii_txd_o carries nibble bits [3:2] while mii_tx_clk_o is low.
- R5: rmii_tx_en_o takes the captured transmit enable with the first dibit of the nibble and holds it through the second dibit. It changes only as mii_tx_clk_o rises.
- R6: If a nibble is captured with both enable and error high, both of its dibits are 2'b01, as are those of every later nibble, while enable stays high.
- R7: Capturing a nibble with enable low clears the error state, so the next frame is sent unmodified.
- R8: While rmii_tx_en_o is low, rmii_txd_o is 2'b00.
- R9: rmii_txd_o changes only on an edge where mii_tx_clk_o also changes, so at 10 Mbps each dibit is stable for 10 cycles.
- R10: An error flag captured with enable low has no effect: no data is sent for that nibble, and the frame that follows is sent unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mii_txd_i | input | 4 | MII transmit nibble from the MAC |
| mii_tx_en_i | input | 1 | MII transmit enable |
| mii_tx_er_i | input | 1 | MII transmit error |
| mii_tx_clk_o | output | 1 | Generated MII transmit clock |
| rmii_txd_o | output | 2 | RMII transmit dibit to the PHY |
| rmii_tx_en_o | output | 1 | RMII transmit enable to the PHY |

## Verification
A divider or phase register that slips shows up at once: the next MII clock phase is too short or too long, and dibits no longer line up with its edges. A swapped dibit order shows up on the first nibble sent, because every test nibble has different low and high pairs. An error state that sticks or clears wrongly is only visible at the first nibble of the following frame. For that reason every error scenario ends with a fresh frame whose data must come out unmodified.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic {
    RATE_100M = 1'b0,
    RATE_10M  = 1'b1
  } rate_e;

  localparam int unsigned NIB_W    = 4;
  localparam int unsigned DIBIT_W  = 2;
  localparam int unsigned SLOW_DIV = 10;

  typedef logic [DIBIT_W-1:0] dibit_t;
  typedef logic [NIB_W-1:0]   nibble_t;

  localparam dibit_t ERR_DIBIT  = 2'b01;
  localparam dibit_t IDLE_DIBIT = 2'b00;

  function automatic int unsigned dibit_cycles(rate_e r);
    return (r == RATE_10M) ? SLOW_DIV : 1;
  endfunction
endpackage

// File: rtl/mrt_tick_gen.sv
module mrt_tick_gen #(
  parameter int unsigned DIBIT_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cap_o,
  output logic mid_o,
  output logic mii_clk_o
);
  logic tick;
  logic phase_q;  // 1: next tick captures a nibble
  logic clk_q;

  generate
    if (DIBIT_CYCLES == 1) begin : g_full
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIBIT_CYCLES);
      logic [CW-1:0] cnt_q;
      assign tick = (cnt_q == CW'(DIBIT_CYCLES - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b1;
      clk_q   <= 1'b0;
    end else if (tick) begin
      phase_q <= ~phase_q;
      clk_q   <= phase_q;
    end
  end

  assign cap_o     = tick & phase_q;
  assign mid_o     = tick & ~phase_q;
  assign mii_clk_o = clk_q;
endmodule

// File: rtl/mrt_err_track.sv
module mrt_err_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic tx_en_i,
  input  logic tx_er_i,
  output logic force_o
);
  logic err_q;

  // force applies to the nibble that raised the error as well
  assign force_o = tx_en_i & (err_q | tx_er_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (cap_i) err_q <= force_o;
  end
endmodule

// File: rtl/mrt_serializer.sv
module mrt_serializer
  import mrt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cap_i,
  input  logic    mid_i,
  input  nibble_t nib_i,
  input  logic    en_i,
  input  logic    force_i,
  output dibit_t  txd_o,
  output logic    en_o
);
  dibit_t lo_d, hi_d, hi_q, txd_q;
  logic   en_q;

  always_comb begin
    if (!en_i) begin
      lo_d = IDLE_DIBIT;
      hi_d = IDLE_DIBIT;
    end else if (force_i) begin
      lo_d = ERR_DIBIT;
      hi_d = ERR_DIBIT;
    end else begin
      lo_d = nib_i[DIBIT_W-1:0];
      hi_d = nib_i[NIB_W-1:DIBIT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q <= IDLE_DIBIT;
      hi_q  <= IDLE_DIBIT;
      en_q  <= 1'b0;
    end else if (cap_i) begin
      txd_q <= lo_d;
      hi_q  <= hi_d;
      en_q  <= en_i;
    end else if (mid_i) begin
      txd_q <= hi_q;
    end
  end

  assign txd_o = txd_q;
  assign en_o  = en_q;
endmodule

// File: rtl/mii_rmii_tx_bridge.sv
module mii_rmii_tx_bridge
  import mrt_pkg::*;
#(
  parameter rate_e RATE = RATE_100M
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mii_txd_i,
  input  logic       mii_tx_en_i,
  input  logic       mii_tx_er_i,
  output logic       mii_tx_clk_o,
  output logic [1:0] rmii_txd_o,
  output logic       rmii_tx_en_o
);
  localparam int unsigned DIBIT_CYCLES = dibit_cycles(RATE);

  logic cap, mid, force_err;

  mrt_tick_gen #(.DIBIT_CYCLES(DIBIT_CYCLES)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_o    (cap),
    .mid_o    (mid),
    .mii_clk_o(mii_tx_clk_o)
  );

  mrt_err_track u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .tx_en_i(mii_tx_en_i),
    .tx_er_i(mii_tx_er_i),
    .force_o(force_err)
  );

  mrt_serializer u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .mid_i  (mid),
    .nib_i  (mii_txd_i),
    .en_i   (mii_tx_en_i),
    .force_i(force_err),
    .txd_o  (rmii_txd_o),
    .en_o   (rmii_tx_en_o)
  );
endmodule

// File: rtl/mrt_tx_checker.sv
module mrt_tx_checker
  import mrt_pkg::*;
#(
  parameter rate_e RATE = RATE_100M
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mii_tx_en_i,
  input logic       mii_tx_er_i,
  input logic       mii_tx_clk_o,
  input logic [1:0] rmii_txd_o,
  input logic       rmii_tx_en_o
);
  localparam int unsigned D = dibit_cycles(RATE);

  logic        prev_clk_q, past_ok_q, in_en_q, in_er_q, err_m_q;
  logic [1:0]  txd_prev_q;
  logic [4:0]  run_q;
  logic        rise, err_now;

  assign rise    = mii_tx_clk_o & ~prev_clk_q;
  assign err_now = rise ? (in_en_q & (err_m_q | in_er_q)) : err_m_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_clk_q <= 1'b0;
      past_ok_q  <= 1'b0;
      in_en_q    <= 1'b0;
      in_er_q    <= 1'b0;
      err_m_q    <= 1'b0;
      txd_prev_q <= 2'b00;
      run_q      <= '0;
    end else begin
      prev_clk_q <= mii_tx_clk_o;
      past_ok_q  <= 1'b1;
      in_en_q    <= mii_tx_en_i;
      in_er_q    <= mii_tx_er_i;
      err_m_q    <= err_now;
      txd_prev_q <= rmii_txd_o;
      if (mii_tx_clk_o != prev_clk_q) run_q <= 5'd1;
      else if (run_q != 5'd31)        run_q <= run_q + 5'd1;
    end
  end

  AST_CLK_RUN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 5'(D)); // R2
  AST_CLK_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mii_tx_clk_o != prev_clk_q) |-> run_q == 5'(D)); // R2
  AST_EN_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |-> rmii_tx_en_o == in_en_q); // R5
  AST_EN_ONLY_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !rise) |-> rmii_tx_en_o == $past(rmii_tx_en_o)); // R5
  AST_ERR_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_now |-> (rmii_tx_en_o && rmii_txd_o == 2'b01)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rmii_tx_en_o |-> rmii_txd_o == 2'b00); // R8
  AST_TXD_ON_CLK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && rmii_txd_o != txd_prev_q) |-> mii_tx_clk_o != prev_clk_q); // R9
endmodule

bind mii_rmii_tx_bridge mrt_tx_checker #(.RATE(RATE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mii_tx_en_i (mii_tx_en_i),
  .mii_tx_er_i (mii_tx_er_i),
  .mii_tx_clk_o(mii_tx_clk_o),
  .rmii_txd_o  (rmii_txd_o),
  .rmii_tx_en_o(rmii_tx_en_o)
);

// File: tb/tb_mii_rmii_tx_bridge.sv
module tb_mii_rmii_tx_bridge;
  import mrt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [3:0] txd_f, txd_s;
  logic en_f, en_s, er_f, er_s;
  logic clk_f, clk_s, ten_f, ten_s;
  logic [1:0] rd_f, rd_s;

  mii_rmii_tx_bridge #(.RATE(RATE_100M)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mii_txd_i(txd_f), .mii_tx_en_i(en_f),
    .mii_tx_er_i(er_f), .mii_tx_clk_o(clk_f), .rmii_txd_o(rd_f), .rmii_tx_en_o(ten_f));

  mii_rmii_tx_bridge #(.RATE(RATE_10M)) dut_slow (
    .clk_i(clk), .rst_ni(rst_n), .mii_txd_i(txd_s), .mii_tx_en_i(en_s),
    .mii_tx_er_i(er_s), .mii_tx_clk_o(clk_s), .rmii_txd_o(rd_s), .rmii_tx_en_o(ten_s));

  int checks = 0;
  int fails  = 0;
  bit err_st [2];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic g_clk(input bit s);  return s ? clk_s : clk_f; endfunction
  function automatic logic [1:0] g_txd(input bit s); return s ? rd_s : rd_f; endfunction
  function automatic logic g_en(input bit s);   return s ? ten_s : ten_f; endfunction

  task automatic drive(input bit s, input bit en, input bit er, input logic [3:0] d);
    if (s) begin en_s = en; er_s = er; txd_s = d; end
    else   begin en_f = en; er_f = er; txd_f = d; end
  endtask

  // leave inputs idle and stop at the first negedge of a low clock phase
  task automatic sync(input bit s);
    drive(s, 1'b0, 1'b0, 4'h0);
    do @(negedge clk); while (g_clk(s) !== 1'b1);
    do @(negedge clk); while (g_clk(s) !== 1'b0);
    err_st[s] = 1'b0;
  endtask

  task automatic send(input bit s, input bit en, input bit er, input logic [3:0] d,
                      input string rq);
    int n = s ? 10 : 1;
    logic [1:0] e0, e1;
    bit bad0 = 0, bad1 = 0;
    logic [1:0] a0 = 2'b00, a1 = 2'b00;
    if (!en)                  begin e0 = 2'b00; e1 = 2'b00; end
    else if (er || err_st[s]) begin e0 = 2'b01; e1 = 2'b01; end
    else                      begin e0 = d[1:0]; e1 = d[3:2]; end
    err_st[s] = en && (err_st[s] || er);
    drive(s, en, er, d);
    do @(negedge clk); while (g_clk(s) !== 1'b1);
    for (int i = 0; i < n; i++) begin
      if (g_txd(s) !== e0 || g_en(s) !== en || g_clk(s) !== 1'b1) begin bad0 = 1; a0 = g_txd(s); end
      @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      if (g_txd(s) !== e1 || g_en(s) !== en || g_clk(s) !== 1'b0) begin bad1 = 1; a1 = g_txd(s); end
      if (i < n - 1) @(negedge clk);
    end
    chk(!bad0, {rq, " first dibit"}, a0, e0);
    chk(!bad1, {rq, " second dibit"}, a1, e1);
  endtask

  task automatic t_reset();
    drive(0, 1'b1, 1'b1, 4'hF);
    drive(1, 1'b1, 1'b1, 4'hF);
    repeat (5) @(negedge clk);
    chk(!ten_f && !ten_s, "R1 tx_en in reset", ten_f | ten_s, 0);
    chk(rd_f == 0 && rd_s == 0, "R1 txd in reset", rd_f | rd_s, 0);
    chk(!clk_f && !clk_s, "R1 mii clk in reset", clk_f | clk_s, 0);
    drive(0, 1'b0, 1'b0, 4'h0);
    drive(1, 1'b0, 1'b0, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_clock(input bit s);
    int hi = 0, lo = 0;
    int n = s ? 10 : 1;
    sync(s);
    do @(negedge clk); while (g_clk(s) !== 1'b1);
    while (g_clk(s) === 1'b1) begin hi++; @(negedge clk); end
    while (g_clk(s) === 1'b0) begin lo++; @(negedge clk); end
    chk(hi == n, "R2 high phase length", hi, n);
    chk(lo == n, "R2 low phase length", lo, n);
  endtask

  task automatic t_frame(input bit s);
    sync(s);
    send(s, 1, 0, 4'hE, "R3 R4 R5 nibble E");
    send(s, 1, 0, 4'h1, "R3 R4 nibble 1");
    send(s, 1, 0, 4'hB, "R3 R4 nibble B");
    send(s, 1, 0, 4'h4, "R5 last nibble 4");
    send(s, 0, 0, 4'h7, "R8 idle after frame");
  endtask

  task automatic t_error(input bit s);
    sync(s);
    send(s, 1, 0, 4'h6, "R6 before error");
    send(s, 1, 1, 4'hA, "R6 error nibble");
    send(s, 1, 0, 4'hF, "R6 after error");
    send(s, 1, 0, 4'h2, "R6 after error");
    send(s, 0, 0, 4'h0, "R7 idle clears");
    send(s, 1, 0, 4'h9, "R7 next frame clean");
    send(s, 0, 0, 4'h0, "R8 idle");
  endtask

  task automatic t_er_idle(input bit s);
    sync(s);
    send(s, 0, 1, 4'hF, "R10 er with en low");
    send(s, 1, 0, 4'hC, "R10 frame unmodified");
    send(s, 0, 0, 4'h0, "R8 idle");
  endtask

  initial begin
    t_reset();
    t_clock(0);
    t_clock(1);           // R9 dibit hold at slow rate
    t_frame(0);
    t_error(0);
    t_er_idle(0);
    t_frame(1);           // R9
    t_error(1);           // R9
    t_er_idle(1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule